// File: doc/BRIEF.md
# I2C Transmit Byte Queue with Acknowledge Halt

This block sits between software and the serial data and clock lines of an I2C controller and handles only the data phase of a write. Software pushes bytes into a queue through a small write port. The block shifts each byte out most significant bit first, releases the data line for the ninth clock and samples the acknowledge there. Generating START and STOP conditions, sending the address and receiving data are handled elsewhere. The queue has a parameter depth (64 by default). The clock low and high phases each last `HALF` cycles of `clk`.

A NAK from the receiver stops the stream at once. The byte engine parks in a halted state, a sticky status flag is raised and a readback bit in the control word shows the halt. The bytes still queued are neither sent nor drained. They stay until software issues a flush, which empties the queue and releases the halt. The flush bit clears itself one cycle after it is written. A "sent and acknowledged" status tells software when to refill, and each of the two main status flags can drive the interrupt line.

Engine states, all named here: `ST_IDLE` waits for a queued byte. `ST_BLO` drives a data bit with the clock low. `ST_BHI` holds that bit with the clock high. `ST_ALO` releases data with the clock low. `ST_AHI` samples the acknowledge with the clock high. `ST_HALT` waits after a NAK. The transitions are:
- `ST_IDLE` to `ST_BLO` when enabled, not flushing and the queue is not empty. The byte is dequeued on this transition.
- `ST_BLO` to `ST_BHI` at the end of the phase.
- `ST_BHI` to `ST_BLO` at the end of the phase while bits remain, or to `ST_ALO` after bit 0.
- `ST_ALO` to `ST_AHI` at the end of the phase.
- `ST_AHI` to `ST_IDLE` at the end of the phase if data was low (ACK), or to `ST_HALT` if it was high (NAK).
- `ST_HALT` to `ST_IDLE` on a flush.

Top module: `i2c_txq`

## Requirements
- R1: After reset the following hold: the queue is disabled and empty, `status_o` = 0x02, `fifo_sts_o` = 0x10, `ctl_o` = 0x00, `irq_o` = 0, `scl_o` = 1 and `sda_oe_o` = 0.
- R2: A write with `reg_sel` = 0 pushes `reg_wdata` when the queue is enabled. Bytes go out in push order, MSB first. Each bit is driven during a clock low phase of `HALF` cycles and held through the following high phase of `HALF` cycles. `sda_oe_o` = 1 pulls the data line low.
- R3: The acknowledge is sampled at the end of the high phase of the ninth clock. A low data line is an ACK, and the next queued byte then follows.
- R4: A high data line at that sample is a NAK. It sets status bit 0 and control readback bit 3, and no further byte is sent until a flush.
- R5: A control write (`reg_sel` = 1) sets the enable from bit 6 and the flush from bit 7. Bit 7 of `ctl_o` reads 1 for exactly one cycle. The queue is then empty, the NAK halt is released and the enable keeps its written value.
- R6: Bit 4 of `fifo_sts_o` is 1 exactly when the queue holds no byte.
- R7: Status bit 1 is 1 only when the queue is empty and no byte is in flight. It rises after the last byte's acknowledge has been sampled, not when that byte is dequeued.
- R8: A push into a queue that holds `DEPTH` bytes, with no dequeue in the same cycle, is dropped and sets sticky status bit 2.
- R9: Pushes while the queue is disabled are dropped, and nothing is sent.
- R10: A write with `reg_sel` = 3 clears each sticky status bit (0 and 2) whose `reg_wdata` bit is 1. A new event in the same cycle wins over the clear.
- R11: `irq_o` = (status bit 0 AND enable bit 0) OR (status bit 1 AND enable bit 1). The enable bits are written with `reg_sel` = 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| reg_we | input | 1 | Write strobe |
| reg_sel | input | 2 | 0 data, 1 control, 2 interrupt enable, 3 status clear |
| reg_wdata | input | 8 | Write data |
| status_o | output | 8 | Bit 0 NAK, bit 1 sent-and-empty, bit 2 overflow |
| fifo_sts_o | output | 8 | Bit 4 queue empty |
| ctl_o | output | 8 | Bit 7 flush, bit 6 enable, bit 3 halted on NAK |
| irq_o | output | 1 | Interrupt request |
| scl_o | output | 1 | Serial clock level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| sda_i | input | 1 | Sampled data line level |

## Verification
The bench builds the block with `DEPTH` = 4 and `HALF` = 2. With those values a byte takes 36 cycles, and a six-push burst is enough to reach the full queue and the dropped push of the overflow case. A bus model captures the shifted bytes and can NAK a chosen byte. This lets the bench check several things: the order of the raw-empty and sent-and-empty flags, a halt that holds with bytes still queued, and the one-cycle flush pulse.

// File: rtl/txq_pkg.sv
package txq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_BLO, ST_BHI, ST_ALO, ST_AHI, ST_HALT
    } eng_state_t;

    localparam logic [1:0] SEL_DATA = 2'd0;
    localparam logic [1:0] SEL_CTL  = 2'd1;
    localparam logic [1:0] SEL_IEN  = 2'd2;
    localparam logic [1:0] SEL_STS  = 2'd3;

    localparam int CTL_FLUSH_BIT = 7;
    localparam int CTL_EN_BIT    = 6;
    localparam int CTL_HALT_BIT  = 3;
    localparam int STS_NAK_BIT   = 0;
    localparam int STS_DONE_BIT  = 1;
    localparam int STS_OVF_BIT   = 2;
    localparam int FST_EMPTY_BIT = 4;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    input  logic         clear_i,
    output logic [W-1:0] dout_o,
    output logic         empty_o,
    output logic         full_o,
    output logic         drop_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] nxt_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CW'(DEPTH));
    assign do_pop  = pop_i && !empty_o && !clear_i;
    assign do_push = push_i && !clear_i && (!full_o || do_pop);
    assign drop_o  = push_i && !clear_i && full_o && !do_pop;
    assign dout_o  = mem[rp_q];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= din_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else if (clear_i) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= nxt_ptr(wp_q);
            if (do_pop)  rp_q <= nxt_ptr(rp_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

    // R8: a push into a full queue without a dequeue leaves it full
    a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i && !clear_i) |=> full_o);
    // R5: a flush leaves the queue empty
    a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> empty_o);
endmodule

// File: rtl/txq_shifter.sv
module txq_shifter
    import txq_pkg::*;
#(
    parameter int HALF = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] byte_i,
    input  logic       release_i,
    input  logic       sda_i,
    output logic       pop_o,
    output logic       busy_o,
    output logic       halted_o,
    output logic       nak_o,
    output logic       scl_o,
    output logic       sda_oe_o
);
    localparam int PW = (HALF > 2) ? $clog2(HALF) : 1;

    eng_state_t    state_q, state_d;
    logic [PW-1:0] ph_q;
    logic [2:0]    bit_q;
    logic [7:0]    sh_q;
    logic          ph_end;

    assign ph_end = (ph_q == PW'(HALF - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)   state_d = ST_BLO;
            ST_BLO:  if (ph_end)    state_d = ST_BHI;
            ST_BHI:  if (ph_end)    state_d = (bit_q == 3'd0) ? ST_ALO : ST_BLO;
            ST_ALO:  if (ph_end)    state_d = ST_AHI;
            ST_AHI:  if (ph_end)    state_d = sda_i ? ST_HALT : ST_IDLE;
            ST_HALT: if (release_i) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ph_q    <= '0;
            bit_q   <= 3'd7;
            sh_q    <= '0;
        end else begin
            state_q <= state_d;
            ph_q    <= (state_d != state_q) ? '0 : ph_q + 1'b1;
            if (state_q == ST_IDLE && start_i) begin
                sh_q  <= byte_i;
                bit_q <= 3'd7;
            end else if (state_q == ST_BHI && ph_end && bit_q != 3'd0) begin
                bit_q <= bit_q - 1'b1;
            end
        end
    end

    always_comb begin
        pop_o    = (state_q == ST_IDLE) && start_i;
        busy_o   = (state_q != ST_IDLE);
        halted_o = (state_q == ST_HALT);
        nak_o    = (state_q == ST_AHI) && ph_end && sda_i;
        scl_o    = (state_q != ST_BLO) && (state_q != ST_ALO);
        sda_oe_o = ((state_q == ST_BLO) || (state_q == ST_BHI)) && !sh_q[bit_q];
    end

    // R2: the data line holds still while the clock is high
    a_r2_sda_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BHI && !ph_end) |=> $stable(sda_oe_o));
    // R3: an ACK returns the engine to idle
    a_r3_ack_continue: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_AHI && ph_end && !sda_i) |=> (state_q == ST_IDLE));
    // R4: the halt holds until a flush
    a_r4_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && !release_i) |=> halted_o);
endmodule

// File: rtl/i2c_txq.sv
module i2c_txq
    import txq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int HALF  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [1:0] reg_sel,
    input  logic [7:0] reg_wdata,
    output logic [7:0] status_o,
    output logic [7:0] fifo_sts_o,
    output logic [7:0] ctl_o,
    output logic       irq_o,
    output logic       scl_o,
    output logic       sda_oe_o,
    input  logic       sda_i
);
    logic       en_q, flush_q, st_nak_q, st_ovf_q;
    logic [1:0] ie_q;
    logic       push, pop, empty, full, drop, start;
    logic       busy, halted, nak;
    logic [7:0] head;
    logic       wr_ctl, wr_ien, wr_sts, tx_done;

    assign wr_ctl = reg_we && (reg_sel == SEL_CTL);
    assign wr_ien = reg_we && (reg_sel == SEL_IEN);
    assign wr_sts = reg_we && (reg_sel == SEL_STS);
    assign push   = reg_we && (reg_sel == SEL_DATA) && en_q;
    assign start  = en_q && !empty && !flush_q;

    txq_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(push), .din_i(reg_wdata),
        .pop_i(pop), .clear_i(flush_q), .dout_o(head),
        .empty_o(empty), .full_o(full), .drop_o(drop)
    );

    txq_shifter #(.HALF(HALF)) u_eng (
        .clk(clk), .rst_n(rst_n), .start_i(start), .byte_i(head),
        .release_i(flush_q), .sda_i(sda_i), .pop_o(pop), .busy_o(busy),
        .halted_o(halted), .nak_o(nak), .scl_o(scl_o), .sda_oe_o(sda_oe_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            flush_q  <= 1'b0;
            ie_q     <= '0;
            st_nak_q <= 1'b0;
            st_ovf_q <= 1'b0;
        end else begin
            flush_q <= wr_ctl && reg_wdata[CTL_FLUSH_BIT];
            if (wr_ctl) en_q <= reg_wdata[CTL_EN_BIT];
            if (wr_ien) ie_q <= reg_wdata[1:0];
            st_nak_q <= nak  || (st_nak_q && !(wr_sts && reg_wdata[STS_NAK_BIT]));
            st_ovf_q <= drop || (st_ovf_q && !(wr_sts && reg_wdata[STS_OVF_BIT]));
        end
    end

    assign tx_done = empty && !busy;

    always_comb begin
        status_o                = '0;
        status_o[STS_NAK_BIT]   = st_nak_q;
        status_o[STS_DONE_BIT]  = tx_done;
        status_o[STS_OVF_BIT]   = st_ovf_q;
        fifo_sts_o              = '0;
        fifo_sts_o[FST_EMPTY_BIT] = empty;
        ctl_o                   = '0;
        ctl_o[CTL_FLUSH_BIT]    = flush_q;
        ctl_o[CTL_EN_BIT]       = en_q;
        ctl_o[CTL_HALT_BIT]     = halted;
        irq_o = (st_nak_q && ie_q[0]) || (tx_done && ie_q[1]);
    end

    // R5: flush bit clears itself unless written again
    a_r5_flush_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_q && !(wr_ctl && reg_wdata[CTL_FLUSH_BIT])) |=> !ctl_o[CTL_FLUSH_BIT]);
    // R7: sent-and-empty implies the raw queue is empty
    a_r7_done_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[STS_DONE_BIT] |-> fifo_sts_o[FST_EMPTY_BIT]);
    // R4: a NAK raises the sticky status
    a_r4_nak_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        nak |=> status_o[STS_NAK_BIT]);
    // R9: nothing is dequeued while disabled
    a_r9_no_pop_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !pop);
endmodule

// File: tb/tb_i2c_txq.sv
module tb_i2c_txq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_sel = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] status_o, fifo_sts_o, ctl_o;
    logic       irq_o, scl_o, sda_oe_o, sda_i;

    int checks = 0;
    int fails  = 0;

    // bus model state
    logic       slave_pull = 1'b0;
    logic       prev_scl = 1'b1;
    int         bitcnt = 0;
    logic [7:0] shreg = '0;
    logic [7:0] rx_mem [16];
    int         rx_count = 0;
    int         nak_idx = -1;

    always #5 clk = ~clk;

    assign sda_i = ~(sda_oe_o | slave_pull);

    i2c_txq #(.DEPTH(4), .HALF(2)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .status_o(status_o), .fifo_sts_o(fifo_sts_o),
        .ctl_o(ctl_o), .irq_o(irq_o), .scl_o(scl_o), .sda_oe_o(sda_oe_o),
        .sda_i(sda_i)
    );

    always @(negedge clk) begin
        if (prev_scl && !scl_o) begin
            slave_pull = (bitcnt == 8) ? (rx_count != nak_idx) : 1'b0;
        end else if (!prev_scl && scl_o) begin
            if (bitcnt < 8) begin
                shreg  = {shreg[6:0], ~sda_oe_o};
                bitcnt = bitcnt + 1;
            end else begin
                if (rx_count < 16) rx_mem[rx_count] = shreg;
                rx_count = rx_count + 1;
                bitcnt   = 0;
            end
        end
        prev_scl = scl_o;
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_bit(input int which, input int idx, input logic val, input int limit);
        for (int i = 0; i < limit; i++) begin
            logic [7:0] v;
            v = (which == 0) ? status_o : fifo_sts_o;
            if (v[idx] === val) return;
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        check(status_o, 8'h02, "R1 status after reset");
        check(fifo_sts_o, 8'h10, "R1 fifo status after reset");
        check(ctl_o, 8'h00, "R1 control after reset");
        check({irq_o, scl_o, sda_oe_o}, 3'b010, "R1 irq/scl/sda after reset");
    endtask

    task automatic t_disabled;
        write_reg(2'd0, 8'hA5);
        idle(60);
        check(fifo_sts_o[4], 1'b1, "R9 push while disabled dropped");
        check(rx_count, 0, "R9 nothing sent while disabled");
    endtask

    task automatic t_stream;
        rx_count = 0;
        write_reg(2'd1, 8'h40);
        write_reg(2'd0, 8'hA5);
        write_reg(2'd0, 8'h3C);
        write_reg(2'd0, 8'hF0);
        check(fifo_sts_o[4], 1'b0, "R6 queue not empty after pushes");
        wait_bit(1, 4, 1'b1, 400);
        check(fifo_sts_o[4], 1'b1, "R6 queue empty once last byte dequeued");
        check(status_o[1], 1'b0, "R7 not done while last byte in flight");
        check(rx_count < 3, 1'b1, "R7 last ack not yet seen at dequeue");
        wait_bit(0, 1, 1'b1, 400);
        check(rx_count, 3, "R3 all bytes acked and sent");
        check(rx_mem[0], 8'hA5, "R2 byte 0 MSB first");
        check(rx_mem[1], 8'h3C, "R2 byte 1 order");
        check(rx_mem[2], 8'hF0, "R2 byte 2 order");
        write_reg(2'd2, 8'h02);
        check(irq_o, 1'b1, "R11 irq from done with enable bit 1");
        write_reg(2'd2, 8'h00);
        check(irq_o, 1'b0, "R11 irq masked");
    endtask

    task automatic t_nak;
        rx_count = 0;
        nak_idx  = 1;
        write_reg(2'd0, 8'h11);
        write_reg(2'd0, 8'h22);
        write_reg(2'd0, 8'h33);
        wait_bit(0, 0, 1'b1, 400);
        check(status_o[0], 1'b1, "R4 NAK status set");
        idle(2);
        check(rx_count, 2, "R4 two bytes on bus at NAK");
        check(ctl_o[3], 1'b1, "R4 halt readback");
        check(fifo_sts_o[4], 1'b0, "R4 third byte still queued");
        check(status_o[1], 1'b0, "R7 not done while halted");
        idle(120);
        check(rx_count, 2, "R4 no byte sent while halted");
        write_reg(2'd2, 8'h01);
        check(irq_o, 1'b1, "R11 irq from NAK with enable bit 0");
        write_reg(2'd3, 8'h01);
        check(status_o[0], 1'b0, "R10 NAK status cleared");
        check(irq_o, 1'b0, "R11 irq drops after clear");
        @(negedge clk);
        reg_we = 1'b1; reg_sel = 2'd1; reg_wdata = 8'hC0;
        @(negedge clk);
        reg_we = 1'b0;
        check(ctl_o[7], 1'b1, "R5 flush bit visible one cycle");
        @(negedge clk);
        check(ctl_o, 8'h40, "R5 flush self-cleared, halt released, enabled");
        check(fifo_sts_o[4], 1'b1, "R5 queue empty after flush");
        check(status_o[1], 1'b1, "R7 done after flush");
        nak_idx = -1;
        idle(120);
        check(rx_count, 2, "R5 flushed byte never sent");
        write_reg(2'd0, 8'h5A);
        wait_bit(0, 1, 1'b0, 20);
        wait_bit(0, 1, 1'b1, 400);
        check(rx_count, 3, "R5 sending resumes after flush");
        check(rx_mem[2], 8'h5A, "R5 resumed byte value");
        write_reg(2'd2, 8'h00);
    endtask

    task automatic t_overflow;
        rx_count = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h81 + 8'(i);
        end
        @(negedge clk);
        reg_we = 1'b0;
        check(status_o[2], 1'b1, "R8 overflow flagged");
        wait_bit(0, 1, 1'b1, 600);
        check(rx_count, 5, "R8 dropped push not sent");
        for (int i = 0; i < 5; i++)
            check(rx_mem[i], 8'h81 + 8'(i), "R8 kept bytes in order");
        write_reg(2'd3, 8'h04);
        check(status_o[2], 1'b0, "R10 overflow cleared");
    endtask

    initial begin
        #(2_000_000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_disabled();
        t_stream();
        t_nak();
        t_overflow();
        idle(5);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule